// File: doc/BRIEF.md
# Feed-forward scan chain load/unload sequencer

This controller sits next to a three-stage feed-forward scan chain. Stage one takes the serial input, stage two copies stage one, and stage three takes stage two XOR (stage one AND the serial input). The last stage drives the serial output. Because of the AND term, the chain does not behave like a plain shift register. For a wanted final state, the sequencer computes the serial bits that must be applied, and it decodes the captured output stream back into the state the chain held before shifting. It needs only the chain's wiring to do this.

One request causes one overlapped pass. The target is shifted in while the old contents are shifted out, in the same number of cycles a plain scan chain would need. No extra cycles are spent between the load and the unload. A build option adds inverters at the chain's serial input and output. These hide the cases where the chain would otherwise act like a shift register. A second option adds a padding flop between the last feed-forward stage and the output, which costs one extra shift cycle.

Top module: `ffsr_scan_sequencer`

## Requirements
- R1: While `rst_n` is low, and after reset until a request arrives, `scan_en` and `done` are 0 and `captured` is 0.
- R2: When `start` is high in an idle cycle, `scan_en` is high for exactly S consecutive cycles, beginning in the following cycle. S is 3, or 4 with the padding flop.
- R3: After the pass, the chain holds the target from any start state. Bit 0 of `target` is stage one, bit 1 is stage two and bit 2 is stage three.
- R4: `captured` equals the chain's contents just before the first shift, using the same bit mapping as R3.
- R5: `done` is high for exactly one cycle, the cycle right after the last `scan_en` cycle. `captured` is valid in that cycle and is 0 in every other cycle.
- R6: Without inverters, the applied serial bits are, in order: t2 XOR (t1 AND t0), then t1, then t0, where tN is `target[N]`. When t0 is 0 this reduces to t2, t1, t0.
- R7: Without inverters or padding, when the first applied bit is 0, the three observed output bits are stage three, stage two and stage one of the old state, in that order.
- R8: With inverters, the chain sees each serial input bit inverted and presents its last stage inverted. Every applied bit is the complement of the R6 value, and R3 and R4 still hold.
- R9: With the padding flop, the first shift cycle applies a filler bit whose internal value is 0, so `scan_in` equals the inverter setting. The first observed bit is not used in the decode.
- R10: A `start` that arrives while a pass is in progress is ignored. The pass keeps its original target and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a load/unload pass (taken only when idle) |
| target | input | 3 | Wanted final chain state, sampled with an accepted start |
| scan_out | input | 1 | Serial output of the chain |
| scan_en | output | 1 | Chain shift enable |
| scan_in | output | 1 | Serial bit applied to the chain |
| done | output | 1 | One-cycle pass-complete strobe |
| captured | output | 3 | Decoded pre-pass chain state, valid with `done` |

## Verification
The bench builds two copies side by side. One uses the default settings, with no inverters and no padding flop. The other uses inverters together with the padding flop, so the filler cycle, the complemented input stream and the shifted decode window are all reached in one run. The plain copy covers the cases where the chain collapses to a shift register, in both directions. The hardened copy shows that the same targets and start states still load and decode correctly once those cases are masked.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  localparam int STAGES   = 3;
  localparam int MAXSHIFT = STAGES + 1;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SHIFT = 2'd1,
    SQ_FIN   = 2'd2
  } sq_state_e;

  // Internal (pre-inverter) bits, indexed by shift cycle, that leave the
  // chain holding tgt. tgt[0] is stage one, tgt[2] is stage three.
  function automatic logic [MAXSHIFT-1:0] load_vector(
    input logic [STAGES-1:0] tgt,
    input bit                pad
  );
    logic [STAGES-1:0]   seq;
    logic [MAXSHIFT-1:0] v;
    seq[0] = tgt[2] ^ (tgt[1] & tgt[0]);
    seq[1] = tgt[1];
    seq[2] = tgt[0];
    v = '0;
    if (pad) v[MAXSHIFT-1:1] = seq;
    else     v[STAGES-1:0]   = seq;
    return v;
  endfunction

  // Recover the pre-pass state from the de-inverted observed bits (obs) and
  // the internal applied bits (app), both indexed by shift cycle.
  function automatic logic [STAGES-1:0] solve_state(
    input logic [MAXSHIFT-1:0] obs,
    input logic [MAXSHIFT-1:0] app,
    input bit                  pad
  );
    logic [STAGES-1:0] w;
    logic [STAGES-1:0] y;
    logic              a0;
    logic              a1;
    w  = pad ? obs[MAXSHIFT-1:1] : obs[STAGES-1:0];
    a0 = app[0];
    a1 = app[1];
    y[2] = w[0];
    y[0] = w[2] ^ (a0 & a1);
    y[1] = w[1] ^ (y[0] & a0);
    return y;
  endfunction

endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int NSHIFT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic busy,
  output logic shift_en,
  output logic [((NSHIFT > 1) ? $clog2(NSHIFT) : 1)-1:0] shift_idx,
  output logic done
);

  localparam int IW = (NSHIFT > 1) ? $clog2(NSHIFT) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NSHIFT - 1);

  sq_state_e     state_q;
  logic [IW-1:0] idx_q;
  logic          last_shift;

  assign last_shift = (state_q == SQ_SHIFT) && (idx_q == LAST_IDX);
  assign accept     = (state_q == SQ_IDLE) && start;
  assign busy       = (state_q != SQ_IDLE);
  assign shift_en   = (state_q == SQ_SHIFT);
  assign done       = (state_q == SQ_FIN);
  assign shift_idx  = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (start) begin
            state_q <= SQ_SHIFT;
            idx_q   <= '0;
          end
        end
        SQ_SHIFT: begin
          if (last_shift) state_q <= SQ_FIN;
          else            idx_q   <= idx_q + 1'b1;
        end
        SQ_FIN:  state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  // Shifting never begins without an accepted request.
  assert_shift_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_en) |-> $past(accept));

  // The strobe lasts one cycle and follows a shift cycle.
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_en) |-> done);

endmodule

// File: rtl/scan_seq_loader.sv
module scan_seq_loader
  import scan_seq_pkg::*;
#(
  parameter bit INV = 1'b0,
  parameter bit PAD = 1'b0,
  parameter int IW  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic [STAGES-1:0]   target,
  input  logic                shift_en,
  input  logic [IW-1:0]       shift_idx,
  output logic [MAXSHIFT-1:0] applied,
  output logic                scan_in
);

  logic [MAXSHIFT-1:0] uvec_q;
  logic                ubit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      uvec_q <= '0;
    else if (accept) uvec_q <= load_vector(target, PAD);
  end

  assign ubit    = uvec_q[shift_idx];
  assign scan_in = shift_en ? (ubit ^ INV) : 1'b0;
  assign applied = uvec_q;

  generate
    if (PAD) begin : g_filler_chk
      // The padded first cycle carries an internal zero.
      assert_filler_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && shift_idx == '0) |-> (scan_in == INV));
    end
  endgenerate

endmodule

// File: rtl/scan_seq_unloader.sv
module scan_seq_unloader
  import scan_seq_pkg::*;
#(
  parameter bit INV = 1'b0,
  parameter bit PAD = 1'b0,
  parameter int IW  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic [IW-1:0]       shift_idx,
  input  logic                scan_out,
  input  logic [MAXSHIFT-1:0] applied,
  output logic [STAGES-1:0]   recovered
);

  logic [MAXSHIFT-1:0] obs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        obs_q            <= '0;
    else if (shift_en) obs_q[shift_idx] <= scan_out ^ INV;
  end

  assign recovered = solve_state(obs_q, applied, PAD);

endmodule

// File: rtl/ffsr_scan_sequencer.sv
module ffsr_scan_sequencer
  import scan_seq_pkg::*;
#(
  parameter bit HARDEN      = 1'b0,
  parameter bit DUMMY_STAGE = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] target,
  input  logic       scan_out,
  output logic       scan_en,
  output logic       scan_in,
  output logic       done,
  output logic [2:0] captured
);

  localparam int NSHIFT = STAGES + (DUMMY_STAGE ? 1 : 0);
  localparam int IW     = (NSHIFT > 1) ? $clog2(NSHIFT) : 1;

  logic                accept;
  logic                busy;
  logic                shift_en;
  logic [IW-1:0]       shift_idx;
  logic                fin;
  logic [MAXSHIFT-1:0] applied;
  logic [STAGES-1:0]   recovered;

  scan_seq_ctrl #(.NSHIFT(NSHIFT)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .accept   (accept),
    .busy     (busy),
    .shift_en (shift_en),
    .shift_idx(shift_idx),
    .done     (fin)
  );

  scan_seq_loader #(.INV(HARDEN), .PAD(DUMMY_STAGE), .IW(IW)) i_load (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .target   (target),
    .shift_en (shift_en),
    .shift_idx(shift_idx),
    .applied  (applied),
    .scan_in  (scan_in)
  );

  scan_seq_unloader #(.INV(HARDEN), .PAD(DUMMY_STAGE), .IW(IW)) i_unload (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .shift_idx(shift_idx),
    .scan_out (scan_out),
    .applied  (applied),
    .recovered(recovered)
  );

  assign scan_en  = shift_en;
  assign done     = fin;
  assign captured = fin ? recovered : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!scan_en && !done && captured == '0);
    end
  end

  // The computed stream stays fixed for a whole pass, even if start is raised again.
  assert_stream_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin) |=> $stable(applied));

  // Outside the strobe cycle the decoded value is held at zero.
  assert_capture_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (captured == '0));

endmodule

// File: tb/test_ffsr_scan_sequencer.sv
module ffsr_chain_model #(
  parameter bit INV = 1'b0,
  parameter bit PAD = 1'b0
) (
  input  logic       clk,
  input  logic       pre_en,
  input  logic [3:0] pre_val,
  input  logic       se,
  input  logic       si,
  output logic       so,
  output logic [3:0] st
);
  logic u;
  assign u  = si ^ INV;
  assign so = (PAD ? st[3] : st[2]) ^ INV;
  always_ff @(posedge clk) begin
    if (pre_en)  st <= pre_val;
    else if (se) st <= {st[2], st[1] ^ (st[0] & u), st[0], u};
  end
endmodule

module test_ffsr_scan_sequencer;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] target = '0;
  logic pre_en = 1'b0;
  logic [3:0] pre_val = '0;

  logic en_w [2];
  logic si_w [2];
  logic so_w [2];
  logic dn_w [2];
  logic [2:0] cap_w [2];
  logic [3:0] st_w [2];

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ffsr_scan_sequencer i_ffsr_scan_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .target(target),
    .scan_out(so_w[0]), .scan_en(en_w[0]), .scan_in(si_w[0]),
    .done(dn_w[0]), .captured(cap_w[0]));

  ffsr_scan_sequencer #(.HARDEN(1'b1), .DUMMY_STAGE(1'b1)) i_ffsr_scan_sequencer_hard (
    .clk(clk), .rst_n(rst_n), .start(start), .target(target),
    .scan_out(so_w[1]), .scan_en(en_w[1]), .scan_in(si_w[1]),
    .done(dn_w[1]), .captured(cap_w[1]));

  ffsr_chain_model #(.INV(1'b0), .PAD(1'b0)) i_chain_plain (
    .clk(clk), .pre_en(pre_en), .pre_val(pre_val), .se(en_w[0]),
    .si(si_w[0]), .so(so_w[0]), .st(st_w[0]));

  ffsr_chain_model #(.INV(1'b1), .PAD(1'b1)) i_chain_hard (
    .clk(clk), .pre_en(pre_en), .pre_val(pre_val), .se(en_w[1]),
    .si(si_w[1]), .so(so_w[1]), .st(st_w[1]));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
      summary();
    end
  end

  // One overlapped pass on both lanes with an identical target and start state.
  task automatic run_op(input logic [2:0] tgt, input logic [3:0] init,
                        input bit restart, input logic [2:0] tgt2);
    int en_cnt [2];
    int first_en [2];
    int done_cnt [2];
    int done_at [2];
    logic [3:0] si_seq [2];
    logic [3:0] so_seq [2];
    logic [2:0] cap [2];
    logic [2:0] exp_seq;
    for (int l = 0; l < 2; l++) begin
      en_cnt[l] = 0; first_en[l] = -1; done_cnt[l] = 0; done_at[l] = -1;
      si_seq[l] = '0; so_seq[l] = '0; cap[l] = '0;
    end
    @(negedge clk); pre_en = 1'b1; pre_val = init;
    @(negedge clk); pre_en = 1'b0;
    start = 1'b1; target = tgt;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 8; i++) begin
      for (int l = 0; l < 2; l++) begin
        if (en_w[l]) begin
          if (first_en[l] < 0) first_en[l] = i;
          si_seq[l][en_cnt[l]] = si_w[l];
          so_seq[l][en_cnt[l]] = so_w[l];
          en_cnt[l]++;
        end
        if (dn_w[l]) begin
          done_cnt[l]++;
          done_at[l] = i;
          cap[l] = cap_w[l];
        end else begin
          chk(cap_w[l] == 3'b000, "R5 captured idle", int'(cap_w[l]), 0);
        end
      end
      if (restart && i == 1) begin start = 1'b1; target = tgt2; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    exp_seq = {tgt[0], tgt[1], tgt[2] ^ (tgt[1] & tgt[0])};
    for (int l = 0; l < 2; l++) begin
      chk(en_cnt[l] == 3 + l && first_en[l] == 0, restart ? "R10 length" : "R2 length",
          en_cnt[l], 3 + l);
      chk(done_cnt[l] == 1 && done_at[l] == 3 + l, "R5 strobe", done_at[l], 3 + l);
      chk(cap[l] == init[2:0], l ? "R8 R4 captured" : "R4 captured",
          int'(cap[l]), int'(init[2:0]));
      chk(st_w[l][2:0] == tgt, restart ? "R10 final state" : (l ? "R8 R3 final" : "R3 final"),
          int'(st_w[l][2:0]), int'(tgt));
    end
    chk(si_seq[0][2:0] == exp_seq, "R6 applied stream", int'(si_seq[0][2:0]), int'(exp_seq));
    chk(si_seq[1][3:1] == ~exp_seq, "R8 inverted stream", int'(si_seq[1][3:1]), int'(~exp_seq));
    chk(si_seq[1][0] == 1'b1, "R9 filler bit", int'(si_seq[1][0]), 1);
    if (exp_seq[0] == 1'b0) begin
      chk(so_seq[0][2:0] == {init[0], init[1], init[2]}, "R7 observed stream",
          int'(so_seq[0][2:0]), int'({init[0], init[1], init[2]}));
    end
  endtask

  task automatic t_reset();
    chk(!en_w[0] && !dn_w[0] && cap_w[0] == '0, "R1 in reset", int'(cap_w[0]), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    for (int l = 0; l < 2; l++)
      chk(!en_w[l] && !dn_w[l] && cap_w[l] == '0, "R1 after reset",
          int'({en_w[l], dn_w[l], cap_w[l]}), 0);
  endtask

  task automatic t_directed();
    run_op(3'b101, 4'b0110, 1'b0, 3'b000);
    run_op(3'b000, 4'b1111, 1'b0, 3'b000);
    run_op(3'b011, 4'b0000, 1'b0, 3'b000);
  endtask

  task automatic t_reversed_load();
    // R6: target stage one is 0, so the stream is the reversed target.
    run_op(3'b110, 4'b1001, 1'b0, 3'b000);
    run_op(3'b100, 4'b0101, 1'b0, 3'b000);
  endtask

  task automatic t_reversed_unload();
    // R7: target 111 makes the first applied bit 0.
    run_op(3'b111, 4'b0011, 1'b0, 3'b000);
    run_op(3'b111, 4'b1100, 1'b0, 3'b000);
  endtask

  task automatic t_busy_start();
    run_op(3'b010, 4'b1011, 1'b1, 3'b101);
  endtask

  task automatic t_random();
    for (int n = 0; n < 24; n++)
      run_op(3'($urandom_range(0, 7)), 4'($urandom_range(0, 15)), 1'b0, 3'b000);
  endtask

  initial begin
    t_reset();
    t_directed();
    t_reversed_load();
    t_reversed_unload();
    t_busy_start();
    t_random();
    summary();
  end

endmodule